// File: doc/BRIEF.md
# Half-Precision Dot-Product Special-Case Resolver

This combinational block sits in front of a two-term dot-product unit. The unit multiplies two pairs of half-precision operands, adds the two products and returns a single-precision value. The resolver looks at the four operands and the mode controls. It decides whether the answer is already fixed by a special case: a NaN operand, an invalid infinity combination, an infinite product, or a sum that is exactly zero because each product has a zero factor. When it is, the block raises `earlyValid`, drives the finished single-precision encoding and reports the invalid-operation flag. Otherwise `earlyValid` stays low, and the finite rounded sum is left to the downstream datapath.

The two products are a1·b1 and a2·b2. Each product's sign is the XOR of its two operand signs. Half-precision encoding is 1 sign bit [15], 5 exponent bits [14:10] and 10 fraction bits [9:0]. Exponent 0x1F marks infinity (fraction zero) or NaN (fraction nonzero). In a NaN, fraction bit 9 set means quiet and clear means signaling. A denormal has exponent 0 and a nonzero fraction. When the alternate half-precision mode is on, exponent 0x1F encodes ordinary numbers, so the NaN and infinity handling is skipped.

Top module: `fpdot_special_top`

## Requirements
- R1: When `flushHalf`=1, each denormal operand is replaced by a zero of the same sign before any other check.
- R2: With `altHalf`=0, the selected NaN is the first match in this order: signaling NaN in a1, a2, b1, b2, then quiet NaN in a1, a2, b1, b2. A NaN result takes priority over every other outcome.
- R3: `invalidFlag` is 1 when the selected NaN is signaling, and 0 when it is quiet.
- R4: With `defaultNan`=1, a NaN result is the default NaN, 0x7FC00000 with bit 31 equal to `altHandling`. With `defaultNan`=0, the result is the selected operand converted as {sign, 0xFF, 1, operand bits [8:0], 13 zeros}.
- R5: With `altHalf`=0 and no NaN, an infinity times a zero in either product is invalid. So are two infinite products of opposite sign. The result is 0x7FC00000 with bit 31 = `altHandling`, and `invalidFlag`=1.
- R6: With `altHalf`=0, no NaN and no invalid case, an infinite product gives 0x7F800000 if its sign is 0 and 0xFF800000 if its sign is 1. `invalidFlag` stays 0.
- R7: When both products have a zero factor, the result is a single-precision zero. Its sign is the common product sign if the two product signs agree. Otherwise it is +0, or -0 when `rndDown`=1.
- R8: With `altHalf`=1, no NaN or infinity result is produced and `invalidFlag` is 0. Only the zero rule of R7 can raise `earlyValid`.
- R9: When no special case applies, `earlyValid`=0, `specResult`=0 and `invalidFlag`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA1 | input | 16 | First factor of product 1 (half precision) |
| opB1 | input | 16 | Second factor of product 1 |
| opA2 | input | 16 | First factor of product 2 |
| opB2 | input | 16 | Second factor of product 2 |
| flushHalf | input | 1 | Flush half-precision denormal operands to zero |
| altHalf | input | 1 | Alternate half-precision mode (no NaN or infinity encodings) |
| defaultNan | input | 1 | Return the default NaN instead of propagating the operand NaN |
| altHandling | input | 1 | Sign of the default NaN |
| rndDown | input | 1 | Rounding toward minus infinity (zero-sum sign) |
| earlyValid | output | 1 | Result fixed by a special case |
| specResult | output | 32 | Single-precision special result |
| invalidFlag | output | 1 | Invalid-operation exception |

## Verification
Some properties are checked by assertions as the inputs change. After flushing, no denormal survives. A picked NaN is a real NaN, and it is signaling whenever any operand is signaling. The exception flag always comes with a valid result. Alternate mode only ever yields a zero. An idle output is all zero. Whether the interleaved NaN order, the payload conversion and the sign rules of infinite and zero sums give the exact bit patterns can only be shown by the bench's directed operand sets.

// File: rtl/fpdot_pkg.sv
package fpdot_pkg;
  localparam int HALF_W      = 16;
  localparam int HALF_EXP_W  = 5;
  localparam int HALF_FRAC_W = 10;
  localparam int SGL_W       = 32;
  localparam int SGL_EXP_W   = 8;
  localparam int SGL_FRAC_W  = 23;
  localparam int NUM_OPS     = 4;
  localparam int OP_IDX_W    = $clog2(NUM_OPS);
  localparam int KEEP_FRAC_W = HALF_FRAC_W - 1;
  localparam int PAD_FRAC_W  = SGL_FRAC_W - 1 - KEEP_FRAC_W;

  typedef struct packed {
    logic sign;
    logic isZero;
    logic isInf;
    logic isSnan;
    logic isQnan;
  } opClass_t;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_NAN,
    SEL_INVALID,
    SEL_INF_POS,
    SEL_INF_NEG,
    SEL_ZERO
  } resSel_e;

  typedef struct packed {
    resSel_e               sel;
    logic [OP_IDX_W-1:0]   nanIdx;
    logic                  zeroSign;
    logic                  raiseInvalid;
  } ctrlStrobes_t;
endpackage

// File: rtl/fpdot_datapath.sv
module fpdot_datapath
  import fpdot_pkg::*;
(
  input  logic [NUM_OPS-1:0][HALF_W-1:0] opsIn,
  input  logic                           flushHalf,
  input  logic                           defaultNan,
  input  logic                           altHandling,
  input  ctrlStrobes_t                   strobes,
  output opClass_t [NUM_OPS-1:0]         classes,
  output logic [SGL_W-1:0]               specResult,
  output logic                           earlyValid
);
  localparam logic [HALF_EXP_W-1:0] HALF_EXP_MAX = '1;
  localparam logic [SGL_EXP_W-1:0]  SGL_EXP_MAX  = '1;

  logic [NUM_OPS-1:0][HALF_W-1:0] flushedOps;

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
    logic                   opSign;
    logic [HALF_EXP_W-1:0]  opExp;
    logic [HALF_FRAC_W-1:0] opFrac;
    logic                   isDenorm;

    assign opSign   = opsIn[i][HALF_W-1];
    assign opExp    = opsIn[i][HALF_W-2 -: HALF_EXP_W];
    assign opFrac   = opsIn[i][HALF_FRAC_W-1:0];
    assign isDenorm = (opExp == '0) && (opFrac != '0);

    always_comb begin
      if (flushHalf && isDenorm) flushedOps[i] = {opSign, {(HALF_W-1){1'b0}}};
      else                       flushedOps[i] = opsIn[i];
    end

    always_comb begin
      classes[i].sign   = flushedOps[i][HALF_W-1];
      classes[i].isZero = flushedOps[i][HALF_W-2:0] == '0;
      classes[i].isInf  = (flushedOps[i][HALF_W-2 -: HALF_EXP_W] == HALF_EXP_MAX) &&
                          (flushedOps[i][HALF_FRAC_W-1:0] == '0);
      classes[i].isSnan = (flushedOps[i][HALF_W-2 -: HALF_EXP_W] == HALF_EXP_MAX) &&
                          (flushedOps[i][HALF_FRAC_W-1:0] != '0) &&
                          !flushedOps[i][HALF_FRAC_W-1];
      classes[i].isQnan = (flushedOps[i][HALF_W-2 -: HALF_EXP_W] == HALF_EXP_MAX) &&
                          flushedOps[i][HALF_FRAC_W-1];
    end

    // R1
    always_comb begin
      flush_done_chk: assert (!(flushHalf &&
                                flushedOps[i][HALF_W-2 -: HALF_EXP_W] == '0 &&
                                flushedOps[i][HALF_FRAC_W-1:0] != '0));
    end
  end

  logic [HALF_W-1:0] nanOp;
  logic [SGL_W-1:0]  convNan;
  logic [SGL_W-1:0]  dfltNan;

  assign nanOp   = flushedOps[strobes.nanIdx];
  assign convNan = {nanOp[HALF_W-1], SGL_EXP_MAX, 1'b1,
                    nanOp[KEEP_FRAC_W-1:0], {PAD_FRAC_W{1'b0}}};
  assign dfltNan = {altHandling, SGL_EXP_MAX, 1'b1, {(SGL_FRAC_W-1){1'b0}}};

  always_comb begin
    earlyValid = 1'b1;
    unique case (strobes.sel)
      SEL_NAN:     specResult = defaultNan ? dfltNan : convNan;
      SEL_INVALID: specResult = dfltNan;
      SEL_INF_POS: specResult = {1'b0, SGL_EXP_MAX, {SGL_FRAC_W{1'b0}}};
      SEL_INF_NEG: specResult = {1'b1, SGL_EXP_MAX, {SGL_FRAC_W{1'b0}}};
      SEL_ZERO:    specResult = {strobes.zeroSign, {(SGL_W-1){1'b0}}};
      default: begin
        specResult = '0;
        earlyValid = 1'b0;
      end
    endcase
  end

  // R4
  always_comb begin
    if (strobes.sel == SEL_NAN && defaultNan)
      dn_frac_chk: assert (specResult[SGL_FRAC_W-2:0] == '0);
  end
endmodule

// File: rtl/fpdot_control.sv
module fpdot_control
  import fpdot_pkg::*;
(
  input  opClass_t [NUM_OPS-1:0] classes,
  input  logic                   altHalf,
  input  logic                   rndDown,
  output ctrlStrobes_t           strobes
);
  // operand order: 0=a1, 1=a2, 2=b1, 3=b2; product 1 = ops 0,2; product 2 = ops 1,3
  logic                snanAny, qnanAny;
  logic [OP_IDX_W-1:0] snanIdx, qnanIdx;

  always_comb begin
    snanAny = 1'b0;
    qnanAny = 1'b0;
    snanIdx = '0;
    qnanIdx = '0;
    for (int i = 0; i < NUM_OPS; i++) begin
      if (!snanAny && classes[i].isSnan) begin
        snanAny = 1'b1;
        snanIdx = OP_IDX_W'(i);
      end
      if (!qnanAny && classes[i].isQnan) begin
        qnanAny = 1'b1;
        qnanIdx = OP_IDX_W'(i);
      end
    end
  end

  logic sgnP1, sgnP2, infP1, infP2, zeroP1, zeroP2, infTimesZero, infClash;

  assign sgnP1  = classes[0].sign ^ classes[2].sign;
  assign sgnP2  = classes[1].sign ^ classes[3].sign;
  assign infP1  = classes[0].isInf || classes[2].isInf;
  assign infP2  = classes[1].isInf || classes[3].isInf;
  assign zeroP1 = classes[0].isZero || classes[2].isZero;
  assign zeroP2 = classes[1].isZero || classes[3].isZero;
  assign infTimesZero = (infP1 && zeroP1) || (infP2 && zeroP2);
  assign infClash     = infP1 && infP2 && (sgnP1 != sgnP2);

  always_comb begin
    strobes.sel          = SEL_NONE;
    strobes.nanIdx       = '0;
    strobes.zeroSign     = 1'b0;
    strobes.raiseInvalid = 1'b0;
    if (!altHalf && snanAny) begin
      strobes.sel          = SEL_NAN;
      strobes.nanIdx       = snanIdx;
      strobes.raiseInvalid = 1'b1;
    end else if (!altHalf && qnanAny) begin
      strobes.sel    = SEL_NAN;
      strobes.nanIdx = qnanIdx;
    end else if (!altHalf && (infTimesZero || infClash)) begin
      strobes.sel          = SEL_INVALID;
      strobes.raiseInvalid = 1'b1;
    end else if (!altHalf && ((infP1 && !sgnP1) || (infP2 && !sgnP2))) begin
      strobes.sel = SEL_INF_POS;
    end else if (!altHalf && (infP1 || infP2)) begin
      strobes.sel = SEL_INF_NEG;
    end else if (zeroP1 && zeroP2) begin
      strobes.sel      = SEL_ZERO;
      strobes.zeroSign = (sgnP1 == sgnP2) ? sgnP1 : rndDown;
    end
  end

  // R2
  always_comb begin
    if (strobes.sel == SEL_NAN) begin
      nan_pick_chk: assert ((classes[strobes.nanIdx].isSnan || classes[strobes.nanIdx].isQnan) &&
                            (!snanAny || classes[strobes.nanIdx].isSnan));
    end
  end
endmodule

// File: rtl/fpdot_special_top.sv
module fpdot_special_top
  import fpdot_pkg::*;
(
  input  logic [15:0] opA1,
  input  logic [15:0] opB1,
  input  logic [15:0] opA2,
  input  logic [15:0] opB2,
  input  logic        flushHalf,
  input  logic        altHalf,
  input  logic        defaultNan,
  input  logic        altHandling,
  input  logic        rndDown,
  output logic        earlyValid,
  output logic [31:0] specResult,
  output logic        invalidFlag
);
  logic [NUM_OPS-1:0][HALF_W-1:0] opsIn;
  opClass_t [NUM_OPS-1:0]         classes;
  ctrlStrobes_t                   strobes;

  assign opsIn = {opB2, opB1, opA2, opA1};

  fpdot_control u_ctrl (
    .classes (classes),
    .altHalf (altHalf),
    .rndDown (rndDown),
    .strobes (strobes)
  );

  fpdot_datapath u_dp (
    .opsIn       (opsIn),
    .flushHalf   (flushHalf),
    .defaultNan  (defaultNan),
    .altHandling (altHandling),
    .strobes     (strobes),
    .classes     (classes),
    .specResult  (specResult),
    .earlyValid  (earlyValid)
  );

  assign invalidFlag = strobes.raiseInvalid;

  always_comb begin
    // R3
    ioc_valid_chk: assert (!invalidFlag || earlyValid);
    // R8
    alt_mode_chk: assert (!(altHalf && earlyValid) || (specResult[30:0] == '0 && !invalidFlag));
    // R9
    idle_out_chk: assert (earlyValid || (specResult == '0 && !invalidFlag));
  end
endmodule

// File: tb/sim_fpdot_special_top.sv
module sim_fpdot_special_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [15:0] opA1, opB1, opA2, opB2;
  logic flushHalf, altHalf, defaultNan, altHandling, rndDown;
  logic earlyValid, invalidFlag;
  logic [31:0] specResult;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  fpdot_special_top u0 (
    .opA1(opA1), .opB1(opB1), .opA2(opA2), .opB2(opB2),
    .flushHalf(flushHalf), .altHalf(altHalf), .defaultNan(defaultNan),
    .altHandling(altHandling), .rndDown(rndDown),
    .earlyValid(earlyValid), .specResult(specResult), .invalidFlag(invalidFlag)
  );

  task automatic setMode(input logic fz, input logic ahp, input logic dn,
                         input logic ah, input logic rdn);
    flushHalf = fz; altHalf = ahp; defaultNan = dn; altHandling = ah; rndDown = rdn;
  endtask

  task automatic apply(input logic [15:0] a1, input logic [15:0] b1,
                       input logic [15:0] a2, input logic [15:0] b2);
    @(negedge clk);
    opA1 = a1; opB1 = b1; opA2 = a2; opB2 = b2;
    #1;
  endtask

  task automatic expect3(input string req, input logic v, input logic [31:0] r, input logic ioc);
    total++;
    if (earlyValid !== v || specResult !== r || invalidFlag !== ioc) begin
      bad++;
      $display("FAIL %s: got valid=%b res=%h ioc=%b, expected valid=%b res=%h ioc=%b",
               req, earlyValid, specResult, invalidFlag, v, r, ioc);
    end
  endtask

  task automatic testIdle();
    setMode(0, 0, 0, 0, 0);
    apply(16'h3C00, 16'h3C00, 16'h3C00, 16'h3C00);
    expect3("R9 finite operands", 1'b0, 32'h0, 1'b0);
  endtask

  task automatic testFlush();
    setMode(1, 0, 0, 0, 0);
    apply(16'h0001, 16'h7C00, 16'h3C00, 16'h3C00);
    expect3("R1 flushed denormal times inf", 1'b1, 32'h7FC00000, 1'b1);
    setMode(0, 0, 0, 0, 0);
    apply(16'h0001, 16'h7C00, 16'h3C00, 16'h3C00);
    expect3("R1 unflushed denormal times inf", 1'b1, 32'h7F800000, 1'b0);
    setMode(1, 0, 0, 0, 0);
    apply(16'h8001, 16'h3C00, 16'h8000, 16'h3C00);
    expect3("R1 R7 flushed negative zeros", 1'b1, 32'h80000000, 1'b0);
  endtask

  task automatic testNanOrder();
    setMode(0, 0, 0, 0, 0);
    apply(16'h7E01, 16'h3C00, 16'h7D23, 16'h3C00);
    expect3("R2 R3 sNaN a2 beats qNaN a1", 1'b1, 32'h7FE46000, 1'b1);
    apply(16'h3C00, 16'hFD05, 16'h7D23, 16'h3C00);
    expect3("R2 sNaN a2 beats sNaN b1", 1'b1, 32'h7FE46000, 1'b1);
    apply(16'h7E01, 16'hFD05, 16'h3C00, 16'h3C00);
    expect3("R2 R4 sNaN b1 conversion", 1'b1, 32'hFFE0A000, 1'b1);
    apply(16'h3C00, 16'hFE55, 16'h3C00, 16'h7E01);
    expect3("R3 R4 quiet b1 no flag", 1'b1, 32'hFFCAA000, 1'b0);
    apply(16'h3C00, 16'hFE55, 16'h7E01, 16'h0000);
    expect3("R2 qNaN a2 beats qNaN b1", 1'b1, 32'h7FC02000, 1'b0);
  endtask

  task automatic testDefaultNan();
    setMode(0, 0, 1, 0, 0);
    apply(16'h7D23, 16'h3C00, 16'h3C00, 16'h3C00);
    expect3("R4 default NaN positive", 1'b1, 32'h7FC00000, 1'b1);
    setMode(0, 0, 1, 1, 0);
    apply(16'h7D23, 16'h3C00, 16'h3C00, 16'h3C00);
    expect3("R4 default NaN signed", 1'b1, 32'hFFC00000, 1'b1);
  endtask

  task automatic testInvalid();
    setMode(0, 0, 0, 1, 0);
    apply(16'h7C00, 16'h0000, 16'h3C00, 16'h3C00);
    expect3("R5 inf times zero, signed", 1'b1, 32'hFFC00000, 1'b1);
    setMode(0, 0, 0, 0, 0);
    apply(16'h7C00, 16'h3C00, 16'hFC00, 16'h3C00);
    expect3("R5 opposite infinite products", 1'b1, 32'h7FC00000, 1'b1);
    apply(16'h3C00, 16'h3C00, 16'h0000, 16'hFC00);
    expect3("R5 zero times inf second", 1'b1, 32'h7FC00000, 1'b1);
  endtask

  task automatic testInf();
    setMode(0, 0, 0, 0, 0);
    apply(16'h7C00, 16'hBC00, 16'h3C00, 16'h3C00);
    expect3("R6 negative inf product", 1'b1, 32'hFF800000, 1'b0);
    apply(16'hFC00, 16'hBC00, 16'h7C00, 16'h7C00);
    expect3("R6 two positive inf products", 1'b1, 32'h7F800000, 1'b0);
  endtask

  task automatic testZero();
    setMode(0, 0, 0, 0, 0);
    apply(16'h8000, 16'h3C00, 16'h0000, 16'h3C00);
    expect3("R7 mixed signs nearest", 1'b1, 32'h00000000, 1'b0);
    setMode(0, 0, 0, 0, 1);
    apply(16'h8000, 16'h3C00, 16'h0000, 16'h3C00);
    expect3("R7 mixed signs round down", 1'b1, 32'h80000000, 1'b0);
    apply(16'h0000, 16'h3C00, 16'h0000, 16'h4000);
    expect3("R7 both positive round down", 1'b1, 32'h00000000, 1'b0);
  endtask

  task automatic testAltHalf();
    setMode(0, 1, 0, 0, 0);
    apply(16'h7D23, 16'h3C00, 16'h3C00, 16'h3C00);
    expect3("R8 NaN pattern ignored", 1'b0, 32'h0, 1'b0);
    apply(16'h7C00, 16'h0000, 16'h0000, 16'h3C00);
    expect3("R8 inf pattern times zero is zero", 1'b1, 32'h00000000, 1'b0);
    apply(16'h7C00, 16'hBC00, 16'h3C00, 16'h3C00);
    expect3("R8 R9 no infinity result", 1'b0, 32'h0, 1'b0);
  endtask

  initial begin
    setMode(0, 0, 0, 0, 0);
    opA1 = '0; opB1 = '0; opA2 = '0; opB2 = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    testIdle();
    testFlush();
    testNanOrder();
    testDefaultNan();
    testInvalid();
    testInf();
    testZero();
    testAltHalf();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule